// File: doc/BRIEF.md
# General-Purpose Pin Port with Resource Routing

This block is an eight-pin general-purpose I/O port that sits on a microcontroller register bus. Software sets each pin as an output or an input with a direction register. It writes the output values through a data register and reads the pins back through that same register. Pull-ups on all pads are active from reset. They stay active until software first writes the direction register, so that no pin floats before it has been configured.

Each pin also has a 3-bit selector held in one of four control registers. The selector can send the pin's synchronized level to one of four shared internal inputs: a gate/clock input for counter 0, a gate/clock input for counter 1, and two external interrupt request lines. A pin can reach an interrupt line as its true level or as its inverted level. All pins that select the same shared input are OR-combined. Edge or level detection of the interrupt lines is done downstream, and the counters are outside this block.

Top module: `gpio_route_port`

## Requirements
- R1: After reset every pin is an input (pad_oe = 0x00). The output latch is 0xFF, every pull-up enable is 1, every selector is 0, and all four resource outputs are 0.
- R2: A write to address 0x91 loads the direction register, one bit per pin. Bit value 0 makes the pin an output (its pad_oe bit is 1) and bit value 1 makes it an input. A read of 0x91 returns the register.
- R3: A write to address 0x90 always updates the output latch, whatever the direction. pad_out shows the latch from the next clock edge.
- R4: A read of 0x90 returns, for each bit, the synchronized pad level if the pin is an input and the output latch bit if the pin is an output.
- R5: pad_pu_en stays 0xFF through any writes other than a direction write. From the clock edge of the first direction write it is 0x00, and later writes never turn it back on.
- R6: Control register n, at address 0xA0+n for n = 0..3, holds the selector of pin 2n in bits [2:0] and the selector of pin 2n+1 in bits [6:4]. Bits 3 and 7 read as 0.
- R7: Selector 1 sends the pin's synchronized true level to res_t0, and selector 2 sends it to res_t1.
- R8: Selectors 3 and 4 send the true level to res_int0 and res_int1. Selectors 5 and 6 send the inverted level to res_int0 and res_int1.
- R9: When several pins select the same resource, that resource output is the OR of their contributions.
- R10: Selectors 0 and 7 route nothing. A resource output is 0 when no pin contributes to it.
- R11: Pad inputs pass through a two-flop synchronizer. A pad change shows in read-back and on the resource outputs after the second rising clock edge, and not after the first.
- R12: Writes to any other address change no register. Reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pad_in | input | 8 | Raw pad input levels |
| pad_oe | output | 8 | Pad output enables, 1 = drive |
| pad_out | output | 8 | Pad output values |
| pad_pu_en | output | 8 | Pad pull-up enables |
| res_t0 | output | 1 | Counter 0 gate/clock input |
| res_t1 | output | 1 | Counter 1 gate/clock input |
| res_int0 | output | 1 | Interrupt 0 request level |
| res_int1 | output | 1 | Interrupt 1 request level |

## Verification
A selector write and a pad change leaving the synchronizer can both take effect at the same clock edge. The resource output must then combine the new selector with the new synchronized level, without mixing in either old value. The bench changes a pad one cycle before it issues a control-register write, so that the second synchronizer stage and the selector register load at the same edge. The interrupt line is checked one half cycle before that edge, where it must be 0, and one half cycle after, where it must be 1.

// File: rtl/gpio_route_pkg.sv
package gpio_route_pkg;

   localparam int unsigned RSRC_N   = 4;
   localparam int unsigned RSRC_T0  = 0;
   localparam int unsigned RSRC_T1  = 1;
   localparam int unsigned RSRC_I0  = 2;
   localparam int unsigned RSRC_I1  = 3;

   typedef enum logic [2:0] {
      SEL_NONE  = 3'd0,
      SEL_T0    = 3'd1,
      SEL_T1    = 3'd2,
      SEL_I0_HI = 3'd3,
      SEL_I1_HI = 3'd4,
      SEL_I0_LO = 3'd5,
      SEL_I1_LO = 3'd6,
      SEL_SPARE = 3'd7
   } route_sel_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned     W       = 8,
   parameter int unsigned     STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("gpio_in_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] chain [STAGES];
   logic         was_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) was_run <= 1'b0;
      else        was_run <= 1'b1;
   end

   generate
      for (genvar k = 0; k < STAGES; k++) begin : g_stage
         if (k == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[k] <= RST_VAL;
               else        chain[k] <= d;
            end
            // R11: first stage is one edge behind the pad
            a_r11_first_stage: assert property (@(posedge clk) disable iff (!rst_n || !was_run)
               chain[k] == $past(d));
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[k] <= RST_VAL;
               else        chain[k] <= chain[k-1];
            end
            // R11: each later stage is one edge behind the one before it
            a_r11_next_stage: assert property (@(posedge clk) disable iff (!rst_n || !was_run)
               chain[k] == $past(chain[k-1]));
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
   import gpio_route_pkg::*;
#(
   parameter int unsigned          PINS      = 8,
   parameter int unsigned          SEL_W     = 3,
   parameter int unsigned          ADDR_W    = 8,
   parameter int unsigned          DATA_W    = 8,
   parameter logic [ADDR_W-1:0]    DATA_ADDR = 8'h90,
   parameter logic [ADDR_W-1:0]    DIR_ADDR  = 8'h91,
   parameter logic [ADDR_W-1:0]    CTL_BASE  = 8'hA0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic                    bus_wr,
   input  logic [DATA_W-1:0]       bus_wdata,
   output logic [DATA_W-1:0]       bus_rdata,
   input  logic [PINS-1:0]         pins_sync,
   output logic [PINS-1:0]         out_latch,
   output logic [PINS-1:0]         dir_q,
   output logic                    pu_hold,
   output logic [PINS*SEL_W-1:0]   sel_flat
);

   localparam int unsigned NUM_CTL    = PINS / 2;
   localparam int unsigned FIELD_SPAN = DATA_W / 2;

   generate
      if (PINS != DATA_W) begin : g_bad_width
         $error("gpio_regfile: PINS must equal DATA_W");
      end
      if (PINS % 2 != 0) begin : g_bad_pins
         $error("gpio_regfile: PINS must be even");
      end
      if (SEL_W + 1 > FIELD_SPAN) begin : g_bad_sel
         $error("gpio_regfile: two selector fields do not fit a word");
      end
   endgenerate

   logic               data_hit;
   logic               dir_hit;
   logic [NUM_CTL-1:0] ctl_hit;
   logic [DATA_W-1:0]  ctl_word [NUM_CTL];

   assign data_hit = (bus_addr == DATA_ADDR);
   assign dir_hit  = (bus_addr == DIR_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_latch <= '1;
         dir_q     <= '1;
         pu_hold   <= 1'b1;
      end else if (bus_wr) begin
         if (data_hit) out_latch <= bus_wdata[PINS-1:0];
         if (dir_hit) begin
            dir_q   <= bus_wdata[PINS-1:0];
            pu_hold <= 1'b0;
         end
      end
   end

   generate
      for (genvar n = 0; n < NUM_CTL; n++) begin : g_ctl
         logic [SEL_W-1:0] lo_q;
         logic [SEL_W-1:0] hi_q;

         assign ctl_hit[n] = (bus_addr == CTL_BASE + ADDR_W'(n));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lo_q <= '0;
               hi_q <= '0;
            end else if (bus_wr && ctl_hit[n]) begin
               lo_q <= bus_wdata[SEL_W-1:0];
               hi_q <= bus_wdata[FIELD_SPAN +: SEL_W];
            end
         end

         assign sel_flat[(2*n)*SEL_W   +: SEL_W] = lo_q;
         assign sel_flat[(2*n+1)*SEL_W +: SEL_W] = hi_q;
         assign ctl_word[n] = (DATA_W'(hi_q) << FIELD_SPAN) | DATA_W'(lo_q);

         // R6: a control write lands in the selector pair of that register
         a_r6_ctl_load: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && ctl_hit[n]) |=> (lo_q == $past(bus_wdata[SEL_W-1:0])));
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (data_hit) begin
         bus_rdata = (dir_q & pins_sync) | (~dir_q & out_latch);
      end else if (dir_hit) begin
         bus_rdata = dir_q;
      end else begin
         for (int n = 0; n < NUM_CTL; n++) begin
            if (ctl_hit[n]) bus_rdata = ctl_word[n];
         end
      end
   end

   // R5: the first direction write releases the pull-ups
   a_r5_pu_release: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && dir_hit) |=> !pu_hold);

   // R5: once released, the pull-ups never return before reset
   a_r5_pu_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !pu_hold |=> !pu_hold);

   // R3: a data write reaches the output latch on the next edge
   a_r3_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && data_hit) |=> (out_latch == $past(bus_wdata[PINS-1:0])));

   // R12: with no write strobe, the data, direction and pull-up state hold
   a_r12_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> ($stable(out_latch) && $stable(dir_q) && $stable(pu_hold)));

endmodule

// File: rtl/gpio_route.sv
module gpio_route
   import gpio_route_pkg::*;
#(
   parameter int unsigned PINS  = 8,
   parameter int unsigned SEL_W = 3
) (
   input  logic [PINS-1:0]        pins_sync,
   input  logic [PINS*SEL_W-1:0]  sel_flat,
   output logic [RSRC_N-1:0]      rsrc
);

   generate
      if (SEL_W != $bits(route_sel_e)) begin : g_bad_sel
         $error("gpio_route: SEL_W must match the selector encoding");
      end
   endgenerate

   logic [PINS*RSRC_N-1:0] contrib_flat;

   generate
      for (genvar p = 0; p < PINS; p++) begin : g_pin
         route_sel_e        sel;
         logic [RSRC_N-1:0] pin_c;

         assign sel = route_sel_e'(sel_flat[p*SEL_W +: SEL_W]);

         always_comb begin
            pin_c = '0;
            unique case (sel)
               SEL_T0:    pin_c[RSRC_T0] =  pins_sync[p];
               SEL_T1:    pin_c[RSRC_T1] =  pins_sync[p];
               SEL_I0_HI: pin_c[RSRC_I0] =  pins_sync[p];
               SEL_I1_HI: pin_c[RSRC_I1] =  pins_sync[p];
               SEL_I0_LO: pin_c[RSRC_I0] = ~pins_sync[p];
               SEL_I1_LO: pin_c[RSRC_I1] = ~pins_sync[p];
               SEL_NONE, SEL_SPARE: pin_c = '0;
               default:   pin_c = '0;
            endcase
         end

         assign contrib_flat[p*RSRC_N +: RSRC_N] = pin_c;
      end
   endgenerate

   always_comb begin
      rsrc = '0;
      for (int p = 0; p < PINS; p++) begin
         rsrc = rsrc | contrib_flat[p*RSRC_N +: RSRC_N];
      end
   end

   // R10: with every selector at zero, no resource is driven
   always_comb begin
      if (sel_flat == '0) begin
         a_r10_idle_quiet: assert (rsrc == '0);
      end
   end

endmodule

// File: rtl/gpio_route_port.sv
module gpio_route_port
   import gpio_route_pkg::*;
#(
   parameter int unsigned       PINS        = 8,
   parameter int unsigned       SEL_W       = 3,
   parameter int unsigned       ADDR_W      = 8,
   parameter int unsigned       DATA_W      = 8,
   parameter int unsigned       SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] DATA_ADDR   = 8'h90,
   parameter logic [ADDR_W-1:0] DIR_ADDR    = 8'h91,
   parameter logic [ADDR_W-1:0] CTL_BASE    = 8'hA0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [PINS-1:0]   pad_in,
   output logic [PINS-1:0]   pad_oe,
   output logic [PINS-1:0]   pad_out,
   output logic [PINS-1:0]   pad_pu_en,
   output logic              res_t0,
   output logic              res_t1,
   output logic              res_int0,
   output logic              res_int1
);

   logic [PINS-1:0]       pins_sync;
   logic [PINS-1:0]       out_latch;
   logic [PINS-1:0]       dir_q;
   logic                  pu_hold;
   logic [PINS*SEL_W-1:0] sel_flat;
   logic [RSRC_N-1:0]     rsrc;

   gpio_in_sync #(
      .W       (PINS),
      .STAGES  (SYNC_STAGES),
      .RST_VAL ('1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (pins_sync)
   );

   gpio_regfile #(
      .PINS      (PINS),
      .SEL_W     (SEL_W),
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .DATA_ADDR (DATA_ADDR),
      .DIR_ADDR  (DIR_ADDR),
      .CTL_BASE  (CTL_BASE)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pins_sync (pins_sync),
      .out_latch (out_latch),
      .dir_q     (dir_q),
      .pu_hold   (pu_hold),
      .sel_flat  (sel_flat)
   );

   gpio_route #(
      .PINS  (PINS),
      .SEL_W (SEL_W)
   ) u_route (
      .pins_sync (pins_sync),
      .sel_flat  (sel_flat),
      .rsrc      (rsrc)
   );

   assign pad_oe    = ~dir_q;
   assign pad_out   = out_latch;
   assign pad_pu_en = {PINS{pu_hold}};
   assign res_t0    = rsrc[RSRC_T0];
   assign res_t1    = rsrc[RSRC_T1];
   assign res_int0  = rsrc[RSRC_I0];
   assign res_int1  = rsrc[RSRC_I1];

   // R2: a direction write sets the output enables to its complement
   a_r2_oe_from_dir: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == DIR_ADDR) |=> (pad_oe == ~$past(bus_wdata[PINS-1:0])));

   // R3: pad_out follows a data write on the next edge
   a_r3_pad_out_load: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == DATA_ADDR) |=> (pad_out == $past(bus_wdata[PINS-1:0])));

endmodule

// File: tb/gpio_route_port_bench.sv
`timescale 1ns/1ps
module gpio_route_port_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_addr = 8'h00;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic [7:0] pad_in = 8'hFF;
   logic [7:0] pad_oe, pad_out, pad_pu_en;
   logic       res_t0, res_t1, res_int0, res_int1;

   int checks = 0;
   int fails  = 0;
   logic [2:0] sel_m [8];

   always #5 clk = ~clk;

   gpio_route_port u_gpio_route_port (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu_en(pad_pu_en),
      .res_t0(res_t0), .res_t1(res_t1), .res_int0(res_int0), .res_int1(res_int1)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // all bus activity starts and ends at a falling edge
   task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic settle();
      repeat (2) @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [7:0] res_now();
      return {4'h0, res_int1, res_int0, res_t1, res_t0};
   endfunction

   function automatic logic [7:0] model_res(input logic [7:0] pads);
      logic [3:0] r = 4'h0;
      for (int p = 0; p < 8; p++) begin
         case (sel_m[p])
            3'd1: r[0] = r[0] |  pads[p];
            3'd2: r[1] = r[1] |  pads[p];
            3'd3: r[2] = r[2] |  pads[p];
            3'd4: r[3] = r[3] |  pads[p];
            3'd5: r[2] = r[2] | ~pads[p];
            3'd6: r[3] = r[3] | ~pads[p];
            default: ;
         endcase
      end
      return {4'h0, r};
   endfunction

   task automatic set_ctl(input int n, input logic [2:0] lo, input logic [2:0] hi);
      sel_m[2*n] = lo; sel_m[2*n+1] = hi;
      bus_write(8'hA0 + 8'(n), {1'b0, hi, 1'b0, lo});
   endtask

   task automatic t_reset();
      logic [7:0] d;
      chk("R1 pad_oe", pad_oe, 8'h00);
      chk("R1 pad_out", pad_out, 8'hFF);
      chk("R1 pad_pu_en", pad_pu_en, 8'hFF);
      chk("R1 resources", res_now(), 8'h00);
      for (int n = 0; n < 4; n++) begin
         bus_read(8'hA0 + 8'(n), d);
         chk("R1 selector reset", d, 8'h00);
      end
   endtask

   task automatic t_pullup();
      bus_write(8'h90, 8'h5A);
      chk("R5 pull-ups kept after data write", pad_pu_en, 8'hFF);
      bus_write(8'hA2, 8'h00);
      chk("R5 pull-ups kept after ctl write", pad_pu_en, 8'hFF);
      bus_write(8'h91, 8'hF0);
      chk("R5 pull-ups released", pad_pu_en, 8'h00);
      bus_write(8'h91, 8'hFF);
      chk("R5 pull-ups stay released", pad_pu_en, 8'h00);
   endtask

   task automatic t_direction();
      logic [7:0] d;
      bus_write(8'h91, 8'h3C);
      chk("R2 pad_oe", pad_oe, 8'hC3);
      bus_read(8'h91, d);
      chk("R2 dir readback", d, 8'h3C);
   endtask

   task automatic t_data();
      logic [7:0] d;
      bus_write(8'h91, 8'hFF);
      bus_write(8'h90, 8'hA5);
      chk("R3 latch written while input", pad_out, 8'hA5);
      bus_write(8'h91, 8'h00);
      bus_read(8'h90, d);
      chk("R4 readback all outputs", d, 8'hA5);
   endtask

   task automatic t_readback();
      logic [7:0] d;
      pad_in = 8'h0F;
      bus_write(8'h91, 8'hF0);
      settle();
      bus_read(8'h90, d);
      chk("R4 mixed readback", d, 8'h05);
   endtask

   task automatic t_sync();
      logic [7:0] d;
      bus_write(8'h91, 8'hFF);
      pad_in = 8'h00;
      settle();
      pad_in = 8'h81;
      @(posedge clk); @(negedge clk);
      bus_read(8'h90, d);
      chk("R11 not visible after first edge", d, 8'h00);
      @(posedge clk); @(negedge clk);
      bus_read(8'h90, d);
      chk("R11 visible after second edge", d, 8'h81);
   endtask

   task automatic t_layout();
      logic [7:0] d;
      bus_write(8'hA1, 8'hFF);
      bus_read(8'hA1, d);
      chk("R6 bits 3 and 7 read zero", d, 8'h77);
      set_ctl(1, 3'd0, 3'd0);
      set_ctl(2, 3'd6, 3'd2);
      bus_read(8'hA2, d);
      chk("R6 field placement", d, 8'h26);
      set_ctl(2, 3'd0, 3'd0);
   endtask

   task automatic t_timer();
      pad_in = 8'h00; settle();
      set_ctl(0, 3'd1, 3'd0);
      set_ctl(3, 3'd0, 3'd2);
      chk("R7 timers low", res_now(), model_res(pad_in));
      pad_in = 8'h01; settle();
      chk("R7 t0 true level", res_now(), 8'h01);
      pad_in = 8'h80; settle();
      chk("R7 t1 true level", res_now(), 8'h02);
      set_ctl(0, 3'd0, 3'd0);
      set_ctl(3, 3'd0, 3'd0);
   endtask

   task automatic t_interrupt();
      pad_in = 8'h00; settle();
      set_ctl(1, 3'd3, 3'd4);
      chk("R8 true routes low", res_now(), 8'h00);
      set_ctl(1, 3'd5, 3'd6);
      chk("R8 inverted routes high", res_now(), 8'h0C);
      pad_in = 8'h04; settle();
      chk("R8 int0 inverted", res_now(), model_res(pad_in));
      chk("R8 int0 inverted value", res_now(), 8'h08);
      set_ctl(1, 3'd0, 3'd0);
   endtask

   task automatic t_or();
      pad_in = 8'h00; settle();
      set_ctl(0, 3'd3, 3'd3);
      set_ctl(2, 3'd1, 3'd1);
      chk("R9 none active", res_now(), 8'h00);
      pad_in = 8'h02; settle();
      chk("R9 one of two int0", res_now(), 8'h04);
      pad_in = 8'h23; settle();
      chk("R9 mixed OR", res_now(), model_res(pad_in));
      set_ctl(0, 3'd0, 3'd0);
      set_ctl(2, 3'd0, 3'd0);
   endtask

   task automatic t_none();
      set_ctl(0, 3'd7, 3'd0);
      set_ctl(1, 3'd7, 3'd7);
      pad_in = 8'hFF; settle();
      chk("R10 selector 7 and 0 high pads", res_now(), 8'h00);
      pad_in = 8'h00; settle();
      chk("R10 selector 7 and 0 low pads", res_now(), 8'h00);
      set_ctl(0, 3'd0, 3'd0);
      set_ctl(1, 3'd0, 3'd0);
   endtask

   task automatic t_unmapped();
      logic [7:0] d;
      bus_write(8'h91, 8'h0F);
      bus_write(8'h90, 8'h33);
      bus_write(8'h92, 8'h00);
      bus_write(8'hA4, 8'h11);
      bus_write(8'h8F, 8'hFF);
      chk("R12 pad_oe unchanged", pad_oe, 8'hF0);
      chk("R12 pad_out unchanged", pad_out, 8'h33);
      bus_read(8'h92, d);
      chk("R12 read 0x92", d, 8'h00);
      bus_read(8'hA4, d);
      chk("R12 read 0xA4", d, 8'h00);
      bus_read(8'hA0, d);
      chk("R12 ctl untouched", d, 8'h00);
   endtask

   task automatic t_same_cycle();
      pad_in = 8'h00; settle();
      pad_in = 8'h08;
      @(posedge clk); @(negedge clk);
      chk("R8 before joint edge", res_now(), 8'h00);
      set_ctl(1, 3'd0, 3'd3);
      chk("R8 joint selector and pad edge", res_now(), 8'h04);
      set_ctl(1, 3'd0, 3'd0);
   endtask

   initial begin : watchdog
      #1_000_000;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 8; i++) sel_m[i] = 3'd0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_pullup();
      t_direction();
      t_data();
      t_readback();
      t_sync();
      t_layout();
      t_timer();
      t_interrupt();
      t_or();
      t_none();
      t_unmapped();
      t_same_cycle();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule